// File: doc/BRIEF.md
# Sequential-Access Wake Filter Bank

This block holds eight 32-bit wake-up filter words that software reaches through one register address. A hidden slot pointer picks the word. A write to that address stores data into the selected word. A read from that address returns the selected word. The pointer then steps to the next slot, so software loads a full filter set by writing eight words back to back. It reads the set back the same way.

The pointer steps only when the access strobes the trigger byte lane. In little-endian mode the trigger is the top lane. In big-endian mode it is lane 0. Byte and halfword accesses therefore step the pointer once per 32-bit word, whichever lane order the bus uses. All eight words go in parallel to the matching logic, which sits outside this block.

The pointer is an eight-state machine with states `SLOT_0` through `SLOT_7`. On each cycle it takes one of two transitions. STEP moves to the next slot, and from `SLOT_7` it wraps to `SLOT_0`. STEP is taken when an access at the filter address strobes the trigger lane. HOLD keeps the current slot on every other cycle.

Top module: `wkf_seq_bank`

## Requirements
- R1: After reset, and while reset is held, the pointer is in `SLOT_0`, all eight words are zero and `rd_data` is zero.
- R2: A write (`bus_wr`=1) with `bus_addr` equal to `FILT_ADDR` and all four strobes set stores `bus_wdata` into the word selected by the pointer.
- R3: A read (`bus_rd`=1, `bus_wr`=0) at `FILT_ADDR` loads the selected word into `rd_data` on that clock edge. `rd_data` keeps that value until the next such read.
- R4: With `big_endian`=0, the trigger lane is lane 3 (`bus_strb[3]`). An access at `FILT_ADDR` steps the pointer by one if lane 3 is strobed and leaves it unchanged otherwise.
- R5: With `big_endian`=1, the trigger lane is lane 0 (`bus_strb[0]`). Lane 3 alone then does not step the pointer.
- R6: A write updates only the strobed lanes of the selected word. Lane i is bits 8i+7:8i. All other lanes keep their values.
- R7: A step from `SLOT_7` wraps to `SLOT_0`.
- R8: An access at any address other than `FILT_ADDR` changes no word, does not move the pointer and leaves `rd_data` unchanged.
- R9: If `bus_wr` and `bus_rd` are both high at `FILT_ADDR`, the write is performed and the pointer steps by the trigger rule. `rd_data` is not updated.
- R10: `filt_words` bits 32k+31:32k carry word k and reflect a write from the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address of the access |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_strb | input | 4 | Byte-lane strobes; lane i is bits 8i+7:8i |
| bus_wdata | input | 32 | Write data |
| big_endian | input | 1 | Selects lane 0 as the trigger lane when high |
| rd_data | output | 32 | Word captured by the last read at the filter address |
| filt_words | output | 256 | All eight words; word k at bits 32k+31:32k |

## Verification
The bound checker watches several rules on every cycle:
- The pointer holds when no access hits the filter address, and holds in big-endian mode when lane 0 is not strobed.
- A triggered access advances the pointer by exactly one, modulo eight, which covers the wrap.
- The words change only on a write at the filter address.
- `rd_data` changes only on a plain read and then equals the word the pointer selected.

Some properties only the bench's scenarios can show. These are the exact order in which words are stored and returned, the merging of partial-lane writes into the stored value, the reset contents, and the mapping of words onto `filt_words`.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
    localparam int unsigned WKF_WORDS  = 8;
    localparam int unsigned WKF_LANES  = 4;
    localparam int unsigned WKF_LANE_W = 8;
    localparam int unsigned WKF_DATA_W = WKF_LANES * WKF_LANE_W;
    localparam int unsigned WKF_PTR_W  = $clog2(WKF_WORDS);
    localparam int unsigned WKF_BUS_W  = WKF_WORDS * WKF_DATA_W;

    typedef enum logic [WKF_PTR_W-1:0] {
        SLOT_0 = 3'd0,
        SLOT_1 = 3'd1,
        SLOT_2 = 3'd2,
        SLOT_3 = 3'd3,
        SLOT_4 = 3'd4,
        SLOT_5 = 3'd5,
        SLOT_6 = 3'd6,
        SLOT_7 = 3'd7
    } wkf_slot_e;
endpackage

// File: rtl/wkf_lane_trigger.sv
module wkf_lane_trigger
    import wkf_pkg::*;
#(
    parameter int unsigned HI_LANE = WKF_LANES - 1,
    parameter int unsigned LO_LANE = 0
) (
    input  logic [WKF_LANES-1:0] strb,
    input  logic                 big_endian,
    input  logic                 access,
    output logic                 step
);
    logic hi_hit;
    logic lo_hit;

    always_comb begin
        hi_hit = strb[HI_LANE];
        lo_hit = strb[LO_LANE];
        step   = access & (big_endian ? lo_hit : hi_hit);
    end
endmodule

// File: rtl/wkf_slot_fsm.sv
module wkf_slot_fsm
    import wkf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    output logic [WKF_PTR_W-1:0] slot_idx,
    output logic [WKF_WORDS-1:0] slot_sel
);
    wkf_slot_e state_q;
    wkf_slot_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_0;
        else        state_q <= state_d;
    end

    // transitions: STEP advances with wrap, HOLD keeps the slot
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_0: state_d = step ? SLOT_1 : SLOT_0;
            SLOT_1: state_d = step ? SLOT_2 : SLOT_1;
            SLOT_2: state_d = step ? SLOT_3 : SLOT_2;
            SLOT_3: state_d = step ? SLOT_4 : SLOT_3;
            SLOT_4: state_d = step ? SLOT_5 : SLOT_4;
            SLOT_5: state_d = step ? SLOT_6 : SLOT_5;
            SLOT_6: state_d = step ? SLOT_7 : SLOT_6;
            SLOT_7: state_d = step ? SLOT_0 : SLOT_7;
        endcase
    end

    // outputs
    always_comb begin
        slot_sel = '0;
        slot_idx = '0;
        unique case (state_q)
            SLOT_0: begin slot_idx = 3'd0; slot_sel[0] = 1'b1; end
            SLOT_1: begin slot_idx = 3'd1; slot_sel[1] = 1'b1; end
            SLOT_2: begin slot_idx = 3'd2; slot_sel[2] = 1'b1; end
            SLOT_3: begin slot_idx = 3'd3; slot_sel[3] = 1'b1; end
            SLOT_4: begin slot_idx = 3'd4; slot_sel[4] = 1'b1; end
            SLOT_5: begin slot_idx = 3'd5; slot_sel[5] = 1'b1; end
            SLOT_6: begin slot_idx = 3'd6; slot_sel[6] = 1'b1; end
            SLOT_7: begin slot_idx = 3'd7; slot_sel[7] = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wkf_word_store.sv
module wkf_word_store
    import wkf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_fire,
    input  logic                  rd_fire,
    input  logic [WKF_WORDS-1:0]  slot_sel,
    input  logic [WKF_PTR_W-1:0]  slot_idx,
    input  logic [WKF_LANES-1:0]  strb,
    input  logic [WKF_DATA_W-1:0] wdata,
    output logic [WKF_BUS_W-1:0]  words_flat,
    output logic [WKF_DATA_W-1:0] rd_data
);
    logic [WKF_DATA_W-1:0] word_q [WKF_WORDS];

    for (genvar w = 0; w < WKF_WORDS; w++) begin : g_word
        for (genvar l = 0; l < WKF_LANES; l++) begin : g_lane
            logic lane_we;
            assign lane_we = wr_fire & slot_sel[w] & strb[l];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    word_q[w][l*WKF_LANE_W +: WKF_LANE_W] <= '0;
                else if (lane_we)
                    word_q[w][l*WKF_LANE_W +: WKF_LANE_W] <= wdata[l*WKF_LANE_W +: WKF_LANE_W];
            end
        end
        assign words_flat[w*WKF_DATA_W +: WKF_DATA_W] = word_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_fire) rd_data <= word_q[slot_idx];
    end
endmodule

// File: rtl/wkf_seq_bank.sv
module wkf_seq_bank
    import wkf_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0]    FILT_ADDR = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [WKF_LANES-1:0]  bus_strb,
    input  logic [WKF_DATA_W-1:0] bus_wdata,
    input  logic                  big_endian,
    output logic [WKF_DATA_W-1:0] rd_data,
    output logic [WKF_BUS_W-1:0]  filt_words
);
    logic                 hit;
    logic                 wr_fire;
    logic                 rd_fire;
    logic                 step;
    logic [WKF_PTR_W-1:0] slot_idx;
    logic [WKF_WORDS-1:0] slot_sel;

    assign hit     = (bus_addr == FILT_ADDR);
    assign wr_fire = hit & bus_wr;
    assign rd_fire = hit & bus_rd & ~bus_wr;

    wkf_lane_trigger u_trig (
        .strb       (bus_strb),
        .big_endian (big_endian),
        .access     (wr_fire | rd_fire),
        .step       (step)
    );

    wkf_slot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .slot_idx (slot_idx),
        .slot_sel (slot_sel)
    );

    wkf_word_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .slot_sel   (slot_sel),
        .slot_idx   (slot_idx),
        .strb       (bus_strb),
        .wdata      (bus_wdata),
        .words_flat (filt_words),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/wkf_seq_bank_chk.sv
module wkf_seq_bank_chk
    import wkf_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FILT_ADDR = 8'h40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [WKF_LANES-1:0]  bus_strb,
    input logic                  big_endian,
    input logic [WKF_PTR_W-1:0]  slot_idx,
    input logic [WKF_DATA_W-1:0] rd_data,
    input logic [WKF_BUS_W-1:0]  filt_words
);
    logic                  c_hit;
    logic                  c_any;
    logic                  c_plain_rd;
    logic                  c_trig;
    logic [WKF_DATA_W-1:0] c_cur;

    always_comb begin
        c_hit      = (bus_addr == FILT_ADDR);
        c_any      = c_hit & (bus_wr | bus_rd);
        c_plain_rd = c_hit & bus_rd & ~bus_wr;
        c_trig     = big_endian ? bus_strb[0] : bus_strb[WKF_LANES-1];
        c_cur      = filt_words[slot_idx*WKF_DATA_W +: WKF_DATA_W];
    end

    // R8: no access at the filter address leaves the pointer alone
    assert_ptr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !c_any |=> $stable(slot_idx));

    // R4: an access without its trigger lane does not step
    assert_ptr_notrig_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_any && !c_trig) |=> $stable(slot_idx));

    // R5: big-endian mode ignores lane 3 for stepping
    assert_be_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_any && big_endian && !bus_strb[0]) |=> $stable(slot_idx));

    // R7: a triggered access steps by one modulo eight
    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_any && c_trig) |=> (slot_idx == WKF_PTR_W'($past(slot_idx) + 1'b1)));

    // R8: words change only through a write at the filter address
    assert_words_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_hit && bus_wr) |=> $stable(filt_words));

    // R9: rd_data holds unless a plain read occurs
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !c_plain_rd |=> $stable(rd_data));

    // R3: a plain read returns the selected word
    assert_rdata_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_plain_rd |=> (rd_data == $past(c_cur)));
endmodule

bind wkf_seq_bank wkf_seq_bank_chk #(.ADDR_W(ADDR_W), .FILT_ADDR(FILT_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_strb   (bus_strb),
    .big_endian (big_endian),
    .slot_idx   (slot_idx),
    .rd_data    (rd_data),
    .filt_words (filt_words)
);

// File: tb/tb_wkf_seq_bank.sv
`timescale 1ns/1ps
module tb_wkf_seq_bank;
    localparam logic [7:0] FA   = 8'h40;
    localparam logic [7:0] MISS = 8'h44;
    localparam logic [1:0] OP_W = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  strb;
        logic        be;
        logic        hit;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 4'b1111, 1'b0, 1'b1, 32'hA0A0_0001, 32'h0},
        '{OP_W, 4'b1111, 1'b0, 1'b1, 32'hB1B1_0002, 32'h0},
        '{OP_W, 4'b0111, 1'b0, 1'b1, 32'hC2C2_0003, 32'h0},
        '{OP_W, 4'b1000, 1'b0, 1'b1, 32'hDD00_0000, 32'h0},
        '{OP_W, 4'b1111, 1'b1, 1'b1, 32'h1234_5678, 32'h0},
        '{OP_W, 4'b1110, 1'b1, 1'b1, 32'h9ABC_DEF0, 32'h0},
        '{OP_W, 4'b0001, 1'b1, 1'b1, 32'h0000_0011, 32'h0},
        '{OP_W, 4'b1111, 1'b0, 1'b1, 32'h5555_0005, 32'h0},
        '{OP_W, 4'b1111, 1'b0, 1'b1, 32'h6666_0006, 32'h0},
        '{OP_W, 4'b1111, 1'b0, 1'b1, 32'h7777_0007, 32'h0},
        '{OP_R, 4'b1111, 1'b0, 1'b1, 32'h0, 32'hA0A0_0001},
        '{OP_R, 4'b1111, 1'b0, 1'b1, 32'h0, 32'hB1B1_0002},
        '{OP_R, 4'b0111, 1'b0, 1'b1, 32'h0, 32'hDDC2_0003},
        '{OP_R, 4'b1000, 1'b0, 1'b1, 32'h0, 32'hDDC2_0003},
        '{OP_R, 4'b0001, 1'b1, 1'b1, 32'h0, 32'h1234_5678},
        '{OP_R, 4'b1111, 1'b1, 1'b1, 32'h0, 32'h9ABC_DE11},
        '{OP_R, 4'b1111, 1'b0, 1'b1, 32'h0, 32'h5555_0005},
        '{OP_R, 4'b1111, 1'b0, 1'b0, 32'h0, 32'h5555_0005},
        '{OP_R, 4'b1111, 1'b0, 1'b1, 32'h0, 32'h6666_0006},
        '{OP_R, 4'b1111, 1'b0, 1'b1, 32'h0, 32'h7777_0007},
        '{OP_R, 4'b1111, 1'b0, 1'b1, 32'h0, 32'hA0A0_0001}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [3:0]   bus_strb = '0;
    logic [31:0]  bus_wdata = '0;
    logic         big_endian = 1'b0;
    logic [31:0]  rd_data;
    logic [255:0] filt_words;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wkf_seq_bank #(.ADDR_W(8), .FILT_ADDR(FA)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_strb   (bus_strb),
        .bus_wdata  (bus_wdata),
        .big_endian (big_endian),
        .rd_data    (rd_data),
        .filt_words (filt_words)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negative edge; returns one negative edge later
    task automatic acc(input logic w, input logic r, input logic [3:0] s,
                       input logic be, input logic h, input logic [31:0] d);
        bus_wr     = w;
        bus_rd     = r;
        bus_strb   = s;
        big_endian = be;
        bus_addr   = h ? FA : MISS;
        bus_wdata  = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] word_of(input int k);
        return filt_words[k*32 +: 32];
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", {224'b0, rd_data}, 256'b0);
        chk("R1 words in reset", filt_words, 256'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            acc(TBL[i].op == OP_W, TBL[i].op == OP_R, TBL[i].strb,
                TBL[i].be, TBL[i].hit, TBL[i].wdata);
            if (TBL[i].op == OP_R)
                chk($sformatf("R3/R4/R5/R7/R8 table row %0d", i),
                    {224'b0, rd_data}, {224'b0, TBL[i].exp});
        end

        // R10: word placement on the flat bus
        chk("R10 word2 lanes", {224'b0, word_of(2)}, {224'b0, 32'hDDC2_0003});
        chk("R10 word7 lanes", {224'b0, word_of(7)}, {224'b0, 32'h7777_0007});

        // R9: write and read together, pointer at slot 1
        acc(1'b1, 1'b1, 4'b1111, 1'b0, 1'b1, 32'hEEEE_0101);
        chk("R9 rd_data held", {224'b0, rd_data}, {224'b0, 32'hA0A0_0001});
        chk("R2 word1 written", {224'b0, word_of(1)}, {224'b0, 32'hEEEE_0101});

        // R8: write elsewhere is ignored, pointer stays at slot 2
        acc(1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk("R8 word2 untouched", {224'b0, word_of(2)}, {224'b0, 32'hDDC2_0003});
        acc(1'b0, 1'b1, 4'b1111, 1'b0, 1'b1, 32'h0);
        chk("R8 pointer not moved", {224'b0, rd_data}, {224'b0, 32'hDDC2_0003});

        // R6: partial write to slot 3, lanes 0 and 2
        acc(1'b1, 1'b0, 4'b0101, 1'b0, 1'b1, 32'h3344_5566);
        chk("R6 lane merge", {224'b0, word_of(3)}, {224'b0, 32'h1244_5666});
        acc(1'b0, 1'b1, 4'b0000, 1'b0, 1'b1, 32'h0);
        chk("R4 no-strobe read", {224'b0, rd_data}, {224'b0, 32'h1244_5666});
        acc(1'b0, 1'b1, 4'b1000, 1'b1, 1'b1, 32'h0);
        chk("R5 lane3 in big-endian", {224'b0, rd_data}, {224'b0, 32'h1244_5666});
        acc(1'b0, 1'b1, 4'b1111, 1'b0, 1'b1, 32'h0);
        chk("R4 step read", {224'b0, rd_data}, {224'b0, 32'h1244_5666});
        acc(1'b0, 1'b1, 4'b1111, 1'b0, 1'b1, 32'h0);
        chk("R5 single step seen", {224'b0, rd_data}, {224'b0, 32'h9ABC_DE11});

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rd_data after reset", {224'b0, rd_data}, 256'b0);
        chk("R1 words after reset", filt_words, 256'b0);
        rst_n = 1'b1;
        @(negedge clk);
        acc(1'b1, 1'b0, 4'b1111, 1'b0, 1'b1, 32'hCAFE_0000);
        chk("R1 pointer back to slot 0", {224'b0, word_of(0)}, {224'b0, 32'hCAFE_0000});

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule